// File: doc/BRIEF.md
# Receive-Only Byte Request Tracker

This block drives receive-only transfers on an SPI master. Software, or a controller above it, writes a byte count. The block then lets the serial shift engine run with nothing to send and counts down the bytes still owed. It packs the incoming bits into 32-bit words for a receive FIFO. In this mode the word size is always four bytes, whatever word length the rest of the master uses.

When the count is not a multiple of four, the last word goes out partial. A byte-count field travels with every word: 4 for a full word and 1 to 3 for a short final word. The bytes of a short word sit at the low end of the word, and the earliest byte is the most significant of them.

Words leave on a valid/ready stream. The word output is held steady while valid is high and ready is low. During such a stall the block pulls its run request low, so the shift engine stops and no bit can be lost. The FIFO and the serial clock generator sit outside this block.

Top module: `rx_only_tracker`

## Requirements
- R1: A request write with a nonzero count, made while the remaining count is zero, loads that count into `todo_bytes`. From the next cycle on, `shift_run` is high, unless the output is stalled.
- R2: A request write is ignored if its count is zero, or if the remaining count is not zero. In both cases `todo_bytes` keeps its value and no clocking starts.
- R3: A bit is accepted when `bit_stb` and `shift_run` are both high. Each eighth accepted bit lowers `todo_bytes` by one. `shift_run` is low whenever `todo_bytes` is zero.
- R4: Bits arrive most significant bit first within each byte. Full words hold four bytes, with the first-received byte in bits 31:24. The word size is fixed at 32 bits.
- R5: When fewer than four bytes remain, the final word carries 1 to 3 bytes, right-aligned, with the earliest byte the most significant of them. The unused upper bytes are zero. `word_nbytes` reports the byte count: 1 to 3 for a partial word, 4 for a full word.
- R6: While `word_valid` is high and `word_ready` is low, `word_data` and `word_nbytes` hold steady, `word_valid` stays high, and `shift_run` is low.
- R7: `busy` rises in the cycle after an accepted request. It falls after the handshake of the last word, once the remaining count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Request write strobe |
| req_bytes | input | 16 | Byte count carried by a request write |
| todo_bytes | output | 16 | Bytes still to be received |
| shift_run | output | 1 | Run request to the serial shift engine |
| busy | output | 1 | Transfer in progress |
| bit_stb | input | 1 | One received bit is present on `bit_in` |
| bit_in | input | 1 | Received serial bit |
| word_valid | output | 1 | Output word available |
| word_ready | input | 1 | Downstream FIFO can take a word |
| word_data | output | 32 | Packed receive word |
| word_nbytes | output | 3 | Valid bytes in `word_data` (1 to 4) |

## Verification
An accepted request shows on `todo_bytes` and `busy` one edge later. `shift_run` follows `word_valid`, `word_ready` and `todo_bytes` within the same cycle. A word appears on `word_valid` one edge after its last bit is taken. `todo_bytes` drops on the same edge that takes the eighth bit of a byte. The bench drives its inputs, and samples every output, one nanosecond after the falling edge. It compares `todo_bytes` every cycle against the number of bits it has actually handed over, and it decides whether to strobe a bit from the `shift_run` value it has just sampled. Counts from 1 to 13 are swept under three ready patterns, so every partial-word length meets both stalled and unstalled hand-offs.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
  parameter int unsigned DEF_CNT_W      = 16;
  parameter int unsigned DEF_WORD_BYTES = 4;
  parameter int unsigned BYTE_BITS      = 8;
endpackage

// File: rtl/rxo_req_ctrl.sv
module rxo_req_ctrl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic [CNT_W-1:0] req_bytes,
  input  logic             byte_done,
  output logic [CNT_W-1:0] todo,
  output logic             active,
  output logic             last_byte
);
  logic accept;

  assign accept    = req_wr && (req_bytes != '0) && (todo == '0);
  assign active    = (todo != '0);
  assign last_byte = (todo == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)         todo <= '0;
    else if (accept)    todo <= req_bytes;
    else if (byte_done) todo <= todo - CNT_W'(1);
  end
endmodule

// File: rtl/rxo_packer.sv
module rxo_packer #(
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned BYTE_BITS  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take,
  input  logic                          bit_in,
  input  logic                          last_byte,
  output logic                          byte_done,
  output logic                          push,
  output logic [WORD_BYTES*BYTE_BITS-1:0] push_data,
  output logic [$clog2(WORD_BYTES+1)-1:0] push_nbytes
);
  localparam int unsigned WORD_W = WORD_BYTES * BYTE_BITS;
  localparam int unsigned BIT_CW = $clog2(BYTE_BITS);
  localparam int unsigned BYT_CW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam int unsigned NB_W   = $clog2(WORD_BYTES + 1);

  logic [WORD_W-1:0] shreg;
  logic [BIT_CW-1:0] bit_cnt;
  logic [BYT_CW-1:0] byte_cnt;

  assign byte_done   = take && (bit_cnt == BIT_CW'(BYTE_BITS - 1));
  assign push        = byte_done && ((byte_cnt == BYT_CW'(WORD_BYTES - 1)) || last_byte);
  assign push_data   = {shreg[WORD_W-2:0], bit_in};
  assign push_nbytes = NB_W'(byte_cnt) + NB_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
    end else if (take) begin
      bit_cnt <= byte_done ? '0 : bit_cnt + BIT_CW'(1);
      if (push) begin
        shreg    <= '0;
        byte_cnt <= '0;
      end else begin
        shreg <= {shreg[WORD_W-2:0], bit_in};
        if (byte_done) byte_cnt <= byte_cnt + BYT_CW'(1);
      end
    end
  end
endmodule

// File: rtl/rxo_out_reg.sv
module rxo_out_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NB_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [NB_W-1:0]   ld_nbytes,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic [NB_W-1:0]   nbytes
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      data   <= '0;
      nbytes <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      data   <= ld_data;
      nbytes <= ld_nbytes;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_only_tracker.sv
module rx_only_tracker #(
  parameter int unsigned CNT_W      = rxo_pkg::DEF_CNT_W,
  parameter int unsigned WORD_BYTES = rxo_pkg::DEF_WORD_BYTES,
  localparam int unsigned WORD_W    = WORD_BYTES * rxo_pkg::BYTE_BITS,
  localparam int unsigned NB_W      = $clog2(WORD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic [CNT_W-1:0]  req_bytes,
  output logic [CNT_W-1:0]  todo_bytes,
  output logic              shift_run,
  output logic              busy,
  input  logic              bit_stb,
  input  logic              bit_in,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [WORD_W-1:0] word_data,
  output logic [NB_W-1:0]   word_nbytes
);
  logic              active, last_byte, byte_done, push, take, stall;
  logic [WORD_W-1:0] push_data;
  logic [NB_W-1:0]   push_nbytes;

  assign stall     = word_valid && !word_ready;
  assign shift_run = active && !stall;
  assign take      = bit_stb && shift_run;
  assign busy      = active || word_valid;

  rxo_req_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_bytes(req_bytes),
    .byte_done(byte_done), .todo(todo_bytes), .active(active),
    .last_byte(last_byte)
  );

  rxo_packer #(.WORD_BYTES(WORD_BYTES), .BYTE_BITS(rxo_pkg::BYTE_BITS)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .bit_in(bit_in),
    .last_byte(last_byte), .byte_done(byte_done), .push(push),
    .push_data(push_data), .push_nbytes(push_nbytes)
  );

  rxo_out_reg #(.DATA_W(WORD_W), .NB_W(NB_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(push), .ld_data(push_data),
    .ld_nbytes(push_nbytes), .ready(word_ready), .valid(word_valid),
    .data(word_data), .nbytes(word_nbytes)
  );
endmodule

// File: rtl/rx_only_tracker_chk.sv
module rx_only_tracker_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NB_W   = 3,
  parameter int unsigned WBYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_wr,
  input logic [CNT_W-1:0]  req_bytes,
  input logic [CNT_W-1:0]  todo_bytes,
  input logic              shift_run,
  input logic              busy,
  input logic              word_valid,
  input logic              word_ready,
  input logic [WORD_W-1:0] word_data,
  input logic [NB_W-1:0]   word_nbytes
);
  // R6
  a_r6_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |=> word_valid && $stable(word_data) && $stable(word_nbytes));
  // R6
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |-> !shift_run);
  // R3
  a_r3_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
    todo_bytes == '0 |-> !shift_run);
  // R3
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    todo_bytes != '0 |=> todo_bytes <= $past(todo_bytes));
  // R2
  a_r2_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr && req_bytes == '0 && todo_bytes == '0 |=> todo_bytes == '0);
  // R5
  a_r5_nbytes_range: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word_nbytes != '0 && word_nbytes <= NB_W'(WBYTES));
  // R7
  a_r7_busy_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr && req_bytes != '0 && todo_bytes == '0 |=> busy);
endmodule

bind rx_only_tracker rx_only_tracker_chk #(
  .CNT_W(CNT_W), .WORD_W(WORD_W), .NB_W(NB_W), .WBYTES(WORD_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_bytes(req_bytes),
  .todo_bytes(todo_bytes), .shift_run(shift_run), .busy(busy),
  .word_valid(word_valid), .word_ready(word_ready),
  .word_data(word_data), .word_nbytes(word_nbytes)
);

// File: tb/rx_only_tracker_tb.sv
`timescale 1ns/1ps
module rx_only_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_wr = 1'b0;
  logic [15:0] req_bytes = '0;
  logic [15:0] todo_bytes;
  logic        shift_run, busy;
  logic        bit_stb = 1'b0, bit_in = 1'b0;
  logic        word_valid;
  logic        word_ready = 1'b1;
  logic [31:0] word_data;
  logic [2:0]  word_nbytes;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_only_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_bytes(req_bytes),
    .todo_bytes(todo_bytes), .shift_run(shift_run), .busy(busy),
    .bit_stb(bit_stb), .bit_in(bit_in), .word_valid(word_valid),
    .word_ready(word_ready), .word_data(word_data), .word_nbytes(word_nbytes)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_val(input int n, input int i);
    return 8'((n * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic bit ready_for(input int mode, input int c);
    case (mode)
      0: return 1'b1;
      1: return (c % 3) == 0;
      default: return (c % 7) < 3;
    endcase
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic run_transfer(input int n, input int mode, input bit poke);
    int acc = 0, widx = 0, nwords, it = 0;
    bit held = 0;
    logic [31:0] hdata;
    logic [2:0]  hnb;
    nwords = (n + 3) / 4;
    @(negedge clk);
    req_wr = 1'b1; req_bytes = 16'(n); bit_stb = 1'b0;
    @(negedge clk);
    req_wr = 1'b0;
    #1;
    chk(todo_bytes == 16'(n), "R1 todo load", todo_bytes, n);
    chk(busy == 1'b1, "R7 busy rise", busy, 1);
    while (widx < nwords && it < 3000) begin
      if (it > 0) @(negedge clk);
      it++;
      req_wr = 1'b0;
      word_ready = ready_for(mode, cyc);
      if (poke && it == 12) begin
        req_wr = 1'b1; req_bytes = 16'd99;   // R2 write while busy
      end
      #1;
      chk(todo_bytes == 16'(n - acc / 8), "R3 R2 todo", todo_bytes, n - acc / 8);
      if (held) begin
        chk(word_valid && word_data == hdata && word_nbytes == hnb,
            "R6 hold", word_data, hdata);
      end
      held = 0;
      if (word_valid && !word_ready) begin
        chk(!shift_run, "R6 stall stops run", shift_run, 0);
        held = 1; hdata = word_data; hnb = word_nbytes;
      end
      if (word_valid && word_ready) begin
        int nb = (n - 4 * widx < 4) ? n - 4 * widx : 4;
        logic [31:0] exp = '0;
        for (int j = 0; j < nb; j++) exp = (exp << 8) | 32'(byte_val(n, 4 * widx + j));
        chk(word_data == exp, (nb < 4) ? "R5 partial data" : "R4 word data", word_data, exp);
        chk(word_nbytes == 3'(nb), "R5 nbytes", word_nbytes, nb);
        widx++;
      end
      if (shift_run && acc < 8 * n) begin
        logic [7:0] b = byte_val(n, acc / 8);
        bit_stb = 1'b1;
        bit_in  = b[7 - (acc % 8)];
        acc++;
      end else begin
        bit_stb = 1'b0;
      end
    end
    chk(widx == nwords, "R4 word count", widx, nwords);
    @(negedge clk);
    bit_stb = 1'b0; req_wr = 1'b0; word_ready = 1'b1;
    #1;
    chk(!busy && !word_valid, "R7 busy fall", busy, 0);
    chk(!shift_run && todo_bytes == 0, "R3 stop at zero", todo_bytes, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(todo_bytes == 0 && !busy && !shift_run && !word_valid, "R1 reset state", todo_bytes, 0);
    @(negedge clk);
    req_wr = 1'b1; req_bytes = 16'd0;
    @(negedge clk);
    req_wr = 1'b0;
    #1;
    chk(todo_bytes == 0, "R2 zero count todo", todo_bytes, 0);
    chk(!shift_run && !busy, "R2 zero count no run", shift_run, 0);
    for (int mode = 0; mode < 3; mode++)
      for (int n = 1; n <= 13; n++)
        run_transfer(n, mode, n == 9);
    summary();
  end
endmodule